// File: doc/BRIEF.md
# Wired-AND Line Repeater Controller

This block sequences the drivers of one line (clock or data) of a bidirectional two-wire repeater. The repeater joins a long cable to a short local display bus. Analog comparators on each side turn the line voltages into threshold flags, and the controller reads those flags. It returns enables for the drivers:

- a cable-side pull-down
- a cable-side active pull-up
- a display-side pull-down
- a series-mode clamp that holds the line low
- a cable back-termination

When either side starts to fall, or both sides are released, the controller decides on a transition. It drives the new level hard for a fixed window. It then keeps sensing blind until a holdoff period ends, so that reflections on the cable cannot trigger a second decision.

One instance is placed per line. The `IS_DATA` parameter selects the data variant, which has a shorter holdoff and an extra way out of the high-holdoff state. `mode_par` selects how a low line is handled:

- Series operation (`mode_par` = 0): the clamp keeps the line low while the repeater owns it.
- Parallel operation (`mode_par` = 1): all drivers are released once the pull-down window ends.

`drv_en` gates every driver off. The sequencing keeps running while the drivers are gated.

All time windows are whole cycles of `clk`, computed from `CLK_KHZ` and rounded up. At the default 50 MHz the windows are:
- driver window: 88 cycles
- clock-variant holdoff: 125 cycles
- data-variant holdoff: 100 cycles

Top module: `wired_and_rptr_ctrl`

## Requirements
- R1: Reset forces every enable low and places the controller in high holdoff with the timer expired. After reset, no fall is acted on until both sides have read above 85% of supply.
- R2: In idle, either side dropping below 75% asserts `cab_pd_en`, `dsp_pd_en` and `term_en` three cycles after the flag changes: two synchroniser stages, then the state register. All three stay asserted for exactly the driver window (1.75 us rounded up, 88 cycles at the default clock).
- R3: From a transition decision until the holdoff expires, threshold flags have no effect.
- R4: A low-to-high decision is made only when the cable side is above 12.5% and the display side is above 17.5% in the same cycle. One side released alone drives nothing new.
- R5: On a rising transition, `cab_pu_en` and `term_en` are asserted for exactly the driver window. During that window neither pull-down is asserted.
- R6: With `mode_par` = 0, `hold_en` is asserted in every low-state cycle from the end of the pull-down window until the rise decision. With `mode_par` = 1, `hold_en` is never asserted.
- R7: After a rise, the controller returns to idle only when the holdoff has expired and both sides are above 85%. Until then, every enable stays low and falls below 75% are ignored.
- R8: When the high holdoff has expired, the data variant (`IS_DATA` = 1) also returns to idle if either side is below 60%. It then acts on a fall one cycle later. The clock variant ignores the 60% level.
- R9: `drv_en` = 0 forces every enable low in the same cycle. State sequencing continues, so the enables reappear as soon as `drv_en` returns high.
- R10: The holdoff is 2.5 us for the clock variant (125 cycles) and 2.0 us for the data variant (100 cycles), counted from the start of the pull-down window. With release already present, `cab_pu_en` rises holdoff+1 cycles after `cab_pd_en` rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_par | input | 1 | 1 = parallel operation, 0 = series operation with low clamp |
| drv_en | input | 1 | 0 gates every driver enable off |
| cab_lt_fall | input | 1 | Cable side below 75% of supply |
| dsp_lt_fall | input | 1 | Display side below 75% of supply |
| cab_gt_rel | input | 1 | Cable side above 12.5% of supply |
| dsp_gt_rel | input | 1 | Display side above 17.5% of supply |
| cab_gt_idle | input | 1 | Cable side above 85% of supply |
| dsp_gt_idle | input | 1 | Display side above 85% of supply |
| cab_lt_mid | input | 1 | Cable side below 60% of supply |
| dsp_lt_mid | input | 1 | Display side below 60% of supply |
| cab_pd_en | output | 1 | Cable-side low-impedance pull-down enable |
| cab_pu_en | output | 1 | Cable-side active pull-up enable |
| dsp_pd_en | output | 1 | Display-side pull-down enable |
| hold_en | output | 1 | Series-mode low clamp enable |
| term_en | output | 1 | Cable back-termination enable |

## Verification
A flag change reaches the enables three clock edges after it is driven. Each check therefore waits three falling edges after the stimulus before sampling; the data early exit takes four, because it passes through idle first. Window lengths are measured by counting falling edges while an enable is high, starting from the first sampled cycle of the pull-down. The bench expects 88 for each window and holdoff+1 for the start of the rise. `drv_en` is combinational, so its effect is sampled one time step after it changes, with no clock edge in between.

// File: rtl/wired_and_rptr_ctrl.sv
module wired_and_rptr_ctrl #(
  parameter int CLK_KHZ     = 50_000,
  parameter bit IS_DATA     = 1'b0,
  parameter int DRV_NS      = 1750,
  parameter int HOLD_NS_CLK = 2500,
  parameter int HOLD_NS_DAT = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_par,
  input  logic drv_en,
  input  logic cab_lt_fall,
  input  logic dsp_lt_fall,
  input  logic cab_gt_rel,
  input  logic dsp_gt_rel,
  input  logic cab_gt_idle,
  input  logic dsp_gt_idle,
  input  logic cab_lt_mid,
  input  logic dsp_lt_mid,
  output logic cab_pd_en,
  output logic cab_pu_en,
  output logic dsp_pd_en,
  output logic hold_en,
  output logic term_en
);
  localparam int HOLD_NS  = IS_DATA ? HOLD_NS_DAT : HOLD_NS_CLK;
  localparam int DRV_CYC  = (CLK_KHZ * DRV_NS + 999_999) / 1_000_000;
  localparam int HOLD_CYC = (CLK_KHZ * HOLD_NS + 999_999) / 1_000_000;
  localparam int CW       = $clog2(HOLD_CYC + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_FALL, S_LOW_WAIT, S_LOW_SENSE, S_RISE, S_HIGH_WAIT
  } st_t;

  st_t           st, st_n;
  logic [CW-1:0] cnt;
  logic [7:0]    sync1, sync2;
  logic          clr;

  wire [7:0] raw = {cab_lt_fall, dsp_lt_fall, cab_gt_rel, dsp_gt_rel,
                    cab_gt_idle, dsp_gt_idle, cab_lt_mid, dsp_lt_mid};

  wire fall_seen = sync2[7] | sync2[6];
  wire both_rel  = sync2[5] & sync2[4];
  wire both_idle = sync2[3] & sync2[2];
  wire mid_drop  = IS_DATA & (sync2[1] | sync2[0]);
  wire drv_done  = (cnt == CW'(DRV_CYC - 1));
  wire hold_last = (cnt >= CW'(HOLD_CYC - 1));

  always_comb begin
    st_n = st;
    clr  = 1'b0;
    case (st)
      S_IDLE:      if (fall_seen) begin st_n = S_FALL; clr = 1'b1; end
      S_FALL:      if (drv_done)  st_n = S_LOW_WAIT;
      S_LOW_WAIT:  if (hold_last) st_n = S_LOW_SENSE;
      S_LOW_SENSE: if (both_rel)  begin st_n = S_RISE; clr = 1'b1; end
      S_RISE:      if (drv_done)  st_n = S_HIGH_WAIT;
      S_HIGH_WAIT: if (hold_last && (both_idle || mid_drop)) st_n = S_IDLE;
      default:     st_n = S_HIGH_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      st    <= S_HIGH_WAIT;
      cnt   <= CW'(HOLD_CYC - 1);
    end else begin
      sync1 <= raw;
      sync2 <= sync1;
      st    <= st_n;
      if (clr)             cnt <= '0;
      else if (!hold_last) cnt <= cnt + CW'(1);
    end
  end

  assign cab_pd_en = drv_en & (st == S_FALL);
  assign dsp_pd_en = drv_en & (st == S_FALL);
  assign cab_pu_en = drv_en & (st == S_RISE);
  assign term_en   = drv_en & ((st == S_FALL) | (st == S_RISE));
  assign hold_en   = drv_en & ~mode_par & ((st == S_LOW_WAIT) | (st == S_LOW_SENSE));
endmodule

module wired_and_rptr_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_par,
  input logic drv_en,
  input logic cab_pd_en,
  input logic cab_pu_en,
  input logic dsp_pd_en,
  input logic hold_en,
  input logic term_en
);
  // R9
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> !(cab_pd_en | cab_pu_en | dsp_pd_en | hold_en | term_en));
  // R5
  pu_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cab_pu_en |-> !cab_pd_en && !dsp_pd_en && !hold_en);
  // R6
  par_nohold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_par |-> !hold_en);
  // R2
  pd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cab_pd_en |-> dsp_pd_en && term_en);
  // R3
  holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cab_pd_en) && drv_en |=> !cab_pd_en && !cab_pu_en);
  // R5
  pu_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cab_pu_en |-> term_en);
endmodule

bind wired_and_rptr_ctrl wired_and_rptr_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_par(mode_par), .drv_en(drv_en),
  .cab_pd_en(cab_pd_en), .cab_pu_en(cab_pu_en), .dsp_pd_en(dsp_pd_en),
  .hold_en(hold_en), .term_en(term_en)
);

// File: tb/wired_and_rptr_ctrl_tb.sv
module wired_and_rptr_ctrl_tb;
  localparam int CLK_PERIOD = 20;
  localparam int DRV    = 88;
  localparam int HOLD_C = 125;
  localparam int HOLD_D = 100;

  logic clk = 1'b0, rst_n = 1'b0, mode_par = 1'b0, drv_en = 1'b1;
  logic cab_lt_fall, dsp_lt_fall, cab_gt_rel, dsp_gt_rel;
  logic cab_gt_idle, dsp_gt_idle, cab_lt_mid, dsp_lt_mid;
  logic c_pd, c_pu, c_dpd, c_hold, c_term;
  logic d_pd, d_pu, d_dpd, d_hold, d_term;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wired_and_rptr_ctrl #(.IS_DATA(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_par(mode_par), .drv_en(drv_en),
    .cab_lt_fall(cab_lt_fall), .dsp_lt_fall(dsp_lt_fall),
    .cab_gt_rel(cab_gt_rel), .dsp_gt_rel(dsp_gt_rel),
    .cab_gt_idle(cab_gt_idle), .dsp_gt_idle(dsp_gt_idle),
    .cab_lt_mid(cab_lt_mid), .dsp_lt_mid(dsp_lt_mid),
    .cab_pd_en(c_pd), .cab_pu_en(c_pu), .dsp_pd_en(c_dpd),
    .hold_en(c_hold), .term_en(c_term));

  wired_and_rptr_ctrl #(.IS_DATA(1'b1)) u_dut_dat (
    .clk(clk), .rst_n(rst_n), .mode_par(mode_par), .drv_en(drv_en),
    .cab_lt_fall(cab_lt_fall), .dsp_lt_fall(dsp_lt_fall),
    .cab_gt_rel(cab_gt_rel), .dsp_gt_rel(dsp_gt_rel),
    .cab_gt_idle(cab_gt_idle), .dsp_gt_idle(dsp_gt_idle),
    .cab_lt_mid(cab_lt_mid), .dsp_lt_mid(dsp_lt_mid),
    .cab_pd_en(d_pd), .cab_pu_en(d_pu), .dsp_pd_en(d_dpd),
    .hold_en(d_hold), .term_en(d_term));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_lines(input int c, input int d);
    cab_lt_fall = c < 75;  dsp_lt_fall = d < 75;
    cab_gt_rel  = c > 12;  dsp_gt_rel  = d > 17;
    cab_gt_idle = c > 85;  dsp_gt_idle = d > 85;
    cab_lt_mid  = c < 60;  dsp_lt_mid  = d < 60;
  endtask

  function automatic int c_all();
    return int'({c_pd, c_pu, c_dpd, c_hold, c_term});
  endfunction
  function automatic int d_all();
    return int'({d_pd, d_pu, d_dpd, d_hold, d_term});
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    set_lines(70, 70);
    wait_n(3);
    chk(c_all() == 0 && d_all() == 0, "R1 reset enables", c_all(), 0);
    rst_n = 1'b1;
    wait_n(10);
    chk(c_all() == 0, "R1 fall ignored before idle (clock)", c_all(), 0);
    chk(d_all() == 0, "R1 fall ignored before idle (data)", d_all(), 0);
    set_lines(100, 100);
    wait_n(6);
  endtask

  task automatic t_series();
    int pd_len = 0, pd_len_d = 0, hold_n = 0, pu_at = -1, pu_at_d = -1;
    int pu_len = 0, pu_len_d = 0, bad = 0, bad_term = 0, early_pu = 0;
    mode_par = 1'b0;
    set_lines(0, 100);
    wait_n(3);
    chk(c_pd && c_dpd && c_term, "R2 cable-side fall latency", c_all(), 5'b10101);
    chk(d_pd && d_dpd && d_term, "R2 cable-side fall latency (data)", d_all(), 5'b10101);
    set_lines(0, 0);
    for (int i = 0; i < 400; i++) begin
      if (c_pd) pd_len++;
      if (d_pd) pd_len_d++;
      if (c_hold) hold_n++;
      if (c_pu && pu_at < 0) pu_at = i;
      if (d_pu && pu_at_d < 0) pu_at_d = i;
      if (c_pu && i <= HOLD_C) early_pu++;
      if (c_pu) pu_len++;
      if (d_pu) pu_len_d++;
      if (c_pu && (c_pd || c_dpd)) bad++;
      if (c_term != (c_pd | c_pu)) bad_term++;
      if (i == 10) set_lines(70, 70);
      @(negedge clk);
    end
    chk(pd_len == DRV, "R2 pull-down window", pd_len, DRV);
    chk(pd_len_d == DRV, "R2 pull-down window (data)", pd_len_d, DRV);
    chk(early_pu == 0, "R3 release ignored during holdoff", early_pu, 0);
    chk(hold_n == HOLD_C - DRV + 1, "R6 series clamp cycles", hold_n, HOLD_C - DRV + 1);
    chk(pu_at == HOLD_C + 1, "R10 clock holdoff", pu_at, HOLD_C + 1);
    chk(pu_at_d == HOLD_D + 1, "R10 data holdoff", pu_at_d, HOLD_D + 1);
    chk(pu_len == DRV, "R5 pull-up window", pu_len, DRV);
    chk(pu_len_d == DRV, "R5 pull-up window (data)", pu_len_d, DRV);
    chk(bad == 0, "R5 no pull-down during pull-up", bad, 0);
    chk(bad_term == 0, "R2 R5 termination follows drive", bad_term, 0);
    chk(c_all() == 0 && d_all() == 0, "R7 held in high holdoff below 85%", c_all(), 0);
  endtask

  task automatic t_data_exit();
    set_lines(50, 50);
    wait_n(4);
    chk(d_pd == 1'b1, "R8 data early exit then fall", d_pd, 1);
    chk(c_pd == 1'b0, "R8 clock ignores 60% level", c_pd, 0);
    wait_n(20);
    chk(c_all() == 0, "R8 clock still waiting", c_all(), 0);
    set_lines(100, 100);
    wait_n(400);
    chk(c_all() == 0 && d_all() == 0, "R7 back to idle", c_all(), 0);
  endtask

  task automatic t_parallel();
    mode_par = 1'b1;
    set_lines(100, 0);
    wait_n(3);
    chk(c_pd && c_dpd, "R2 display-side fall latency", c_all(), 5'b10101);
    set_lines(0, 0);
    wait_n(95);
    chk(!c_hold && !c_pd, "R6 parallel no clamp", c_all(), 0);
    wait_n(35);
    set_lines(100, 0);
    wait_n(10);
    chk(!c_pu && !d_pu, "R4 one side released", int'(c_pu), 0);
    chk(!c_hold, "R6 parallel no clamp in low sense", c_hold, 0);
    set_lines(100, 100);
    wait_n(3);
    chk(c_pu && d_pu, "R4 both sides released", int'(c_pu), 1);
    wait_n(400);
  endtask

  task automatic t_disable();
    mode_par = 1'b0;
    drv_en = 1'b0;
    set_lines(0, 0);
    wait_n(5);
    chk(c_all() == 0 && d_all() == 0, "R9 gated during fall", c_all(), 0);
    drv_en = 1'b1;
    #1;
    chk(c_pd && c_dpd, "R9 sequencing continued", c_all(), 5'b10101);
    wait_n(200);
    chk(c_hold == 1'b1, "R6 clamp in low sense", c_hold, 1);
    drv_en = 1'b0;
    #1;
    chk(c_hold == 1'b0, "R9 clamp gated", c_hold, 0);
    drv_en = 1'b1;
    set_lines(100, 100);
    wait_n(400);
    chk(c_all() == 0, "R7 idle after cycle", c_all(), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150_000);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    set_lines(70, 70);
    @(negedge clk);
    t_reset();
    t_series();
    t_data_exit();
    t_parallel();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule